// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block drains 32-bit words from an external transmit FIFO and sends each one as a bipolar return-to-zero bit stream. The stream appears on two logic outputs, one for the positive line level and one for the negative level, which drive an off-chip line driver. When neither output is high, the line is at null. Between words the line stays at null. The first eight bits on the line are the label, sent from its highest bit down. The remaining bits follow in ascending order. The block can optionally replace the top bit of the word with a computed odd-parity bit.

An 8-bit control register sets three things: the line rate (fast or slow), whether parity is inserted, and a FIFO fill threshold. An 8-bit status register reports the FIFO empty, threshold and full conditions. It also reports whether a word is in flight and which rate that word uses. An interrupt output is high whenever any of the three FIFO conditions holds.

The FIFO sits outside the block. It must present its oldest word on `fifo_word` whenever its count is non-zero, and it removes that word on the clock edge where `fifo_pop` is high.

Top module: `arinc_tx`

## Requirements
- R1: Line order is word bits 8,7,6,5,4,3,2,1 and then 9 through 32, where bit 1 is `fifo_word[0]` and a high pulse (`line_hi`) carries a 1.
- R2: When control bit 1 is set at the time a word is taken, bit 32 of that word is replaced so that all 32 sent bits hold an odd number of ones.
- R3: When control bit 1 is clear, bit 32 is sent exactly as supplied.
- R4: Each bit time has two halves: a first half with `line_hi` (for a 1) or `line_lo` (for a 0) high, then a second half at null; the two outputs are never high together.
- R5: A half-bit lasts HALF_FAST clock cycles when control bit 0 is 1 (fast rate) and 8*HALF_FAST cycles when it is 0 (slow rate).
- R6: A control write changes the rate and parity only for words taken after the write, never for the word in flight.
- R7: Between consecutive words the line is null for at least GAP_BITS bit times after the last bit time ends, and it is always null while no word is in flight.
- R8: While idle with a non-zero FIFO count, `fifo_pop` is high for one cycle and that word starts in the next cycle; `fifo_pop` is never high while a word or its gap is in progress.
- R9: Status bit 0 is high when the count is 0, bit 1 when the count is at least control[7:2] times max(1, DEPTH/64), and bit 2 when the count equals DEPTH; all three follow the count in the same cycle.
- R10: `irq` is high exactly when at least one of status bits 0, 1 and 2 is high.
- R11: A control write appears on `ctrl_q` from the cycle after `ctrl_we`; after reset `ctrl_q` is 0.
- R12: Status bit 3 is high from the cycle after a pop until the gap after that word ends, and status bit 4 then shows the rate of that word (1 = fast); bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control value: [0] fast rate, [1] parity insert, [7:2] FIFO threshold |
| ctrl_q | output | 8 | Current control register value |
| status_q | output | 8 | [0] empty, [1] at threshold, [2] full, [3] busy, [4] rate of word in flight |
| irq | output | 1 | High while any FIFO condition flag is high |
| fifo_count | input | $clog2(DEPTH+1) | Number of words in the external FIFO |
| fifo_word | input | 32 | Oldest FIFO word, valid while the count is non-zero |
| fifo_pop | output | 1 | Takes the oldest word on this clock edge |
| line_hi | output | 1 | Positive line level request |
| line_lo | output | 1 | Negative line level request |

## Verification
The status flags and `irq` follow `fifo_count` with no delay, so the bench reads them on the falling edge right after the rising edge that changed the count. `ctrl_q` changes one rising edge after the write strobe. The pop shows in the cycle before the word is taken, so the bench records the expected word, parity mode and rate on the falling edge that sees the pop, using a control shadow updated on the same rising edges as the register. The first half of bit 0 starts one cycle after the pop edge. After that, every pulse and every null stretch is measured in falling-edge samples: inside a word each must be exactly one half-bit long, and between words the null stretch must be at least nine half-bits of the earlier word's rate.

// File: rtl/arinc_tx.sv
module arinc_tx #(
  parameter int DEPTH     = 512,
  parameter int HALF_FAST = 625,
  parameter int GAP_BITS  = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       status_q,
  output logic             irq,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [31:0]      fifo_word,
  output logic             fifo_pop,
  output logic             line_hi,
  output logic             line_lo
);
  localparam int HALF_SLOW = HALF_FAST * 8;
  localparam int HW        = $clog2(HALF_SLOW + 1);
  localparam int GW        = $clog2(2 * GAP_BITS + 1);
  localparam int LVL_STEP  = (DEPTH / 64 > 0) ? DEPTH / 64 : 1;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} st_t;

  st_t            st;
  logic [31:0]    shreg;
  logic [4:0]     bit_n;
  logic           half;
  logic [HW-1:0]  hcnt;
  logic [GW-1:0]  gcnt;
  logic           fast_q;

  logic [HW-1:0]  half_last;
  logic           half_end;
  logic           empty, at_lvl, full, busy;

  function automatic logic [31:0] line_order(input logic [31:0] w, input logic par_en);
    logic [31:0] s;
    logic [31:0] v;
    v = w;
    if (par_en) v[31] = ~^w[30:0];
    for (int i = 0; i < 8; i++) s[i] = v[7-i];
    for (int i = 8; i < 32; i++) s[i] = v[i];
    return s;
  endfunction

  assign half_last = fast_q ? HW'(HALF_FAST - 1) : HW'(HALF_SLOW - 1);
  assign half_end  = (hcnt == half_last);
  assign busy      = (st != S_IDLE);
  assign fifo_pop  = (st == S_IDLE) && (fifo_count != '0);

  assign line_hi = (st == S_SEND) && !half &&  shreg[0];
  assign line_lo = (st == S_SEND) && !half && !shreg[0];

  assign empty    = (fifo_count == '0);
  assign full     = (fifo_count == CNT_W'(DEPTH));
  assign at_lvl   = 32'(fifo_count) >= 32'(ctrl_q[7:2]) * LVL_STEP;
  assign status_q = {3'b000, fast_q, busy, full, at_lvl, empty};
  assign irq      = empty | at_lvl | full;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= 8'h00;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      shreg  <= '0;
      bit_n  <= '0;
      half   <= 1'b0;
      hcnt   <= '0;
      gcnt   <= '0;
      fast_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (fifo_pop) begin
            shreg  <= line_order(fifo_word, ctrl_q[1]);
            fast_q <= ctrl_q[0];
            bit_n  <= '0;
            half   <= 1'b0;
            hcnt   <= '0;
            st     <= S_SEND;
          end
        end
        S_SEND: begin
          if (half_end) begin
            hcnt <= '0;
            half <= ~half;
            if (half) begin
              shreg <= shreg >> 1;
              bit_n <= bit_n + 5'd1;
              if (bit_n == 5'd31) begin
                gcnt <= '0;
                st   <= S_GAP;
              end
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        S_GAP: begin
          if (half_end) begin
            hcnt <= '0;
            gcnt <= gcnt + 1'b1;
            if (gcnt == GW'(2 * GAP_BITS - 1)) st <= S_IDLE;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arinc_tx_chk.sv
module arinc_tx_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_pop,
  input logic             line_hi,
  input logic             line_lo,
  input logic [7:0]       status_q,
  input logic             irq
);
  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_hi && line_lo));

  a_r8_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_count != '0));

  a_r8_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

  a_r8_no_pop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !status_q[3]);

  a_r12_busy_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> status_q[3]);

  a_r7_null_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[3] |-> (!line_hi && !line_lo));

  a_r9_empty_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |-> (status_q[0] && !status_q[2]));

  a_r10_irq_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[0] |-> irq);

  a_r6_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[3] |=> $stable(status_q[4]));
endmodule

bind arinc_tx arinc_tx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_count (fifo_count),
  .fifo_pop   (fifo_pop),
  .line_hi    (line_hi),
  .line_lo    (line_lo),
  .status_q   (status_q),
  .irq        (irq)
);

// File: tb/arinc_tx_tb.sv
module arinc_tx_tb;
  localparam int DEPTH = 16;
  localparam int HF    = 3;
  localparam int HS    = HF * 8;
  localparam int GAPB  = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] ctrl_q, status_q;
  logic irq, fifo_pop, line_hi, line_lo;
  logic [CW-1:0] fifo_count;
  logic [31:0] fifo_word;

  always #4 clk = ~clk;

  arinc_tx #(.DEPTH(DEPTH), .HALF_FAST(HF), .GAP_BITS(GAPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .status_q(status_q), .irq(irq),
    .fifo_count(fifo_count), .fifo_word(fifo_word), .fifo_pop(fifo_pop),
    .line_hi(line_hi), .line_lo(line_lo)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // external FIFO model
  logic [31:0] mem [64];
  logic [5:0]  wp, rp;
  logic        push_req = 1'b0;
  logic [31:0] push_data = '0;
  logic [7:0]  shadow;
  int          pushed = 0;

  assign fifo_count = CW'(wp - rp);
  assign fifo_word  = mem[rp];

  always @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; shadow <= 8'h00;
    end else begin
      if (push_req) begin mem[wp] <= push_data; wp <= wp + 6'd1; end
      if (fifo_pop) rp <= rp + 6'd1;
      if (ctrl_we) shadow <= ctrl_wdata;
    end
  end

  function automatic logic [31:0] exp_word(input logic [31:0] w, input bit p);
    logic [31:0] r;
    r = w;
    if (p) r[31] = ~^w[30:0];
    return r;
  endfunction

  // line monitor
  logic [31:0] exp_w [256];
  bit          exp_f [256];
  bit          exp_p [256];
  int exp_wr = 0, exp_rd = 0;
  int in_pulse = 0, plen = 0, nlen = 0, bit_cnt = 0, words_seen = 0, prev_h = 0, cur_h;
  logic [31:0] bits, got;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (fifo_pop) begin
        exp_w[exp_wr] = exp_word(mem[rp], shadow[1]);
        exp_p[exp_wr] = shadow[1];
        exp_f[exp_wr] = shadow[0];
        exp_wr++;
      end
      cur_h = exp_f[exp_rd] ? HF : HS;
      if (line_hi && line_lo) check(0, "R4 both levels", 1, 0);
      if ((line_hi || line_lo) && in_pulse == 0) begin
        if (bit_cnt == 0) begin
          if (words_seen > 0) check(nlen >= 9 * prev_h, "R7 gap", nlen, 9 * prev_h);
          check(exp_rd < exp_wr, "R8 word without pop", exp_rd, exp_wr);
        end else begin
          check(nlen == cur_h, "R4/R5 null half", nlen, cur_h);
        end
        bits[bit_cnt] = line_hi;
        in_pulse = 1;
        plen = 1;
      end else if (line_hi || line_lo) begin
        plen++;
      end else if (in_pulse != 0) begin
        check(plen == cur_h, "R5 pulse width", plen, cur_h);
        in_pulse = 0;
        nlen = 1;
        bit_cnt++;
        if (bit_cnt == 32) begin
          for (int i = 0; i < 32; i++) got[i < 8 ? 7 - i : i] = bits[i];
          if (exp_p[exp_rd]) check(got == exp_w[exp_rd], "R1/R2 word parity on", got, exp_w[exp_rd]);
          else               check(got == exp_w[exp_rd], "R1/R3 word parity off", got, exp_w[exp_rd]);
          prev_h = cur_h;
          exp_rd++;
          words_seen++;
          bit_cnt = 0;
        end
      end else begin
        nlen++;
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    while (fifo_count >= CW'(DEPTH)) @(negedge clk);
    @(negedge clk); push_req = 1'b1; push_data = w; pushed++;
    @(negedge clk); push_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(exp_wr == pushed && exp_rd == pushed && !status_q[3])) @(negedge clk);
  endtask

  initial begin
    logic [7:0] c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset value; R9/R10 reset flags with threshold 0
    check(ctrl_q == 8'h00, "R11 reset ctrl", ctrl_q, 0);
    check(status_q == 8'h03, "R9 reset status", status_q, 8'h03);
    check(irq == 1'b1, "R10 reset irq", irq, 1);
    check(!line_hi && !line_lo && !fifo_pop, "R7 reset null", {line_hi, line_lo, fifo_pop}, 0);

    wr_ctrl(8'h03);
    check(ctrl_q == 8'h03, "R11 ctrl readback", ctrl_q, 8'h03);

    // directed words, fast, parity on then off
    push(32'h0000_0001);
    push(32'h8000_00FF);
    push(32'h0000_0000);
    wait_idle();
    wr_ctrl(8'h01);
    push(32'h8000_0000);
    push(32'h7FFF_FF80);
    wait_idle();

    // status, irq and rate-at-boundary checks around a slow word
    wr_ctrl(8'h00);
    push(32'h1234_5678);
    while (!status_q[3]) @(negedge clk);
    check(status_q[3] && !status_q[4], "R12 busy slow", status_q, 8'h0B);
    check(status_q[0] && fifo_count == 0, "R9 empty while busy", status_q, 8'h0B);
    wr_ctrl(8'h0D);
    push(32'hA5A5_0F0F);
    check(status_q[2:0] == 3'b000, "R9 below threshold", status_q[2:0], 0);
    check(irq == 1'b0, "R10 irq low", irq, 0);
    push(32'h0000_0102);
    push(32'h00FF_FF00);
    check(status_q[2:0] == 3'b010, "R9 at threshold", status_q[2:0], 3'b010);
    check(irq == 1'b1, "R10 irq threshold", irq, 1);
    for (int i = 0; i < DEPTH - 3; i++) push(32'h1000_0000 + i * 32'h0101_0101);
    check(status_q[2:0] == 3'b110, "R9 full", status_q[2:0], 3'b110);
    check(status_q[3] && !status_q[4], "R6 rate held in flight", status_q[4:3], 2'b01);
    wait_idle();
    check(status_q[4] == 1'b1, "R12 last word fast", status_q[4], 1);

    // constrained random
    void'($urandom(32'h429A_0001));
    for (int it = 0; it < 30; it++) begin
      c = 8'($urandom());
      wr_ctrl(c);
      for (int k = 0; k < 1 + ($urandom() % 3); k++) push($urandom());
      if ($urandom() % 3 == 0) wait_idle();
    end
    wait_idle();

    check(words_seen == pushed, "R8 every word sent", words_seen, pushed);
    check(!status_q[3] && !line_hi && !line_lo, "R7 idle null", status_q, 0);
    check(status_q[7:5] == 3'b000, "R12 spare bits", status_q[7:5], 0);
    finish_run();
  end
endmodule